// File: doc/BRIEF.md
# Nibble Receive Start-of-Frame Detector

This block sits on a 4-bit receive path behind a physical-layer device. It watches a data-valid flag, an error flag and four data lines, all sampled on the rising clock edge. While data-valid is high it hunts for the opening flag octet. Once the flag is found, it packs each following pair of nibbles into a byte and passes the byte to a downstream byte interface with a one-cycle strobe. It marks the start of a frame, the end of a frame, a discard condition and a dribble (odd nibble) condition.

A select input picks one of two hunting modes. In aligned mode the incoming nibbles already sit on packet boundaries. The block then looks for nibble 5h followed by nibble Dh and accepts whatever nibbles come before them. In search mode the block treats the input as a serial bit stream and looks for the flag bit pattern at any of the four bit offsets. The offset where the pattern ends sets the nibble alignment for the rest of the frame, so a data nibble may be built from bits of two adjacent input samples.

CRC checking, address filtering and buffering are done downstream. A frame that the error flag has marked is reported through the discard output at frame end, in the same way a CRC failure would be handled.

Top module: `rx_sfd_nibble`

## Requirements
- R1: While reset is asserted, and from the first edge after it, all outputs are low. Reset is asynchronous and takes effect in the middle of a frame as well.
- R2: Data line 0 is the least significant and earliest serial bit of a nibble. In each output byte, bits 3:0 hold the first data nibble and bits 7:4 the second.
- R3: With `search_mode` low, the flag is nibble 5h followed by nibble Dh on two consecutive valid samples. `frm_start` pulses high for one cycle after the edge that samples the Dh. Non-preamble nibbles before the flag do not prevent detection. A flag that is not on a nibble boundary is not detected.
- R4: With `search_mode` high, the flag is the serial bit sequence 1,0,1,0,1,0,1,1 at any bit offset. The earliest match in a sample wins. Data begins with the bit that follows the flag, and that alignment holds until the frame ends. Leftover bits that do not complete a data nibble are dropped.
- R5: `byte_valid` is high for exactly one cycle after the edge that samples the second nibble of each byte. It is never high in the same cycle as `frm_start`.
- R6: After `frm_start`, the first edge that samples `rx_valid` low raises `frm_end` for one cycle.
- R7: If `rx_valid` falls before the flag is found, the block raises no `frm_start`, no `byte_valid` and no `frm_end`.
- R8: If `rx_err` is sampled high on any edge where `rx_valid` is high in a frame that reaches `frm_end`, `frm_discard` is high together with `frm_end`. Otherwise `frm_discard` stays low.
- R9: `frm_dribble` is high together with `frm_end` exactly when an odd number of data nibbles followed the flag.
- R10: After the flag is found, flag patterns inside the data are treated as ordinary data and do not restart the frame.
- R11: A frame with no preamble at all, where the flag is the first thing after `rx_valid` rises, is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| search_mode | input | 1 | 0: aligned flag hunt; 1: serial bit search with realignment |
| rx_valid | input | 1 | Receive data valid |
| rx_err | input | 1 | Receive error marker for the current frame |
| rx_nib | input | 4 | Receive nibble; bit 0 is the earliest bit |
| frm_start | output | 1 | One-cycle pulse when the flag is found |
| byte_valid | output | 1 | One-cycle strobe for `byte_data` |
| byte_data | output | 8 | Assembled byte, first nibble in bits 3:0 |
| frm_end | output | 1 | One-cycle pulse at frame end |
| frm_discard | output | 1 | Frame must be dropped; valid with `frm_end` |
| frm_dribble | output | 1 | Odd data nibble count; valid with `frm_end` |

## Verification
The assertions check these rules on every cycle:
- The start, end and byte strobes keep their timing relation to the sampled `rx_valid`.
- In aligned mode a frame start always follows a sampled Dh nibble.
- The discard and dribble flags never appear without a frame end.
- A byte strobe never lasts two cycles.

Only the bench's frame scenarios show the rest:
- Correct byte values after realignment at each of the four bit offsets.
- The quiet outcome when the flag is missing or lies off a nibble boundary.
- Flag patterns inside the data not restarting the frame.
- An error seen during the hunt still marking the frame.

// File: rtl/rx_sfd_pkg.sv
package rx_sfd_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;
  localparam int WIN_W  = 3 * NIB_W;
  localparam int POS_W  = $clog2(NIB_W);
  localparam int SH_W   = POS_W + 1;
  // flag bits with the earliest serial bit in bit 0: 1,0,1,0,1,0,1,1
  localparam logic [BYTE_W-1:0] FLAG_BITS = 8'hD5;

  typedef enum logic {ST_HUNT, ST_DATA} rx_st_t;

  // window holds {current, previous, older} samples; the match ends at bit pos of current
  function automatic logic flag_at(input logic [WIN_W-1:0] win, input int unsigned pos);
    return win[pos + 1 +: BYTE_W] == FLAG_BITS;
  endfunction

  // rebuild one data nibble that starts sh bits into the previous sample
  function automatic logic [NIB_W-1:0] realign(input logic [NIB_W-1:0] cur,
                                               input logic [NIB_W-1:0] prev,
                                               input logic [SH_W-1:0]  sh);
    logic [2*NIB_W-1:0] pair;
    pair = {cur, prev} >> sh;
    return pair[NIB_W-1:0];
  endfunction
endpackage

// File: rtl/rx_sfd_hist.sv
module rx_sfd_hist
  import rx_sfd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic             search_mode,
  input  logic [NIB_W-1:0] nib,
  output logic [NIB_W-1:0] prev_nib,
  output logic             hit,
  output logic [POS_W-1:0] hit_pos
);
  logic [NIB_W-1:0] p1, p2;
  logic [WIN_W-1:0] win;
  logic [NIB_W-1:0] lane_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1 <= '0;
      p2 <= '0;
    end else if (!valid) begin
      p1 <= '0;
      p2 <= '0;
    end else begin
      p2 <= p1;
      p1 <= nib;
    end
  end

  assign win      = {nib, p1, p2};
  assign prev_nib = p1;

  // one comparator per ending offset; aligned mode keeps only the boundary lane
  for (genvar k = 0; k < NIB_W; k++) begin : g_lane
    assign lane_hit[k] = flag_at(win, k) && ((k == NIB_W - 1) || search_mode);
  end

  always_comb begin
    hit     = 1'b0;
    hit_pos = POS_W'(NIB_W - 1);
    for (int k = NIB_W - 1; k >= 0; k--) begin
      if (lane_hit[k]) begin
        hit     = 1'b1;
        hit_pos = POS_W'(k);
      end
    end
  end
endmodule

// File: rtl/rx_sfd_pack.sv
module rx_sfd_pack
  import rx_sfd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              nib_en,
  input  logic [NIB_W-1:0]  nib,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data,
  output logic              half
);
  logic [NIB_W-1:0] lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q       <= '0;
      half       <= 1'b0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
    end else if (clr) begin
      half       <= 1'b0;
      byte_valid <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      if (nib_en) begin
        if (!half) begin
          lo_q <= nib;
          half <= 1'b1;
        end else begin
          byte_data  <= {nib, lo_q};
          byte_valid <= 1'b1;
          half       <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/rx_sfd_nibble.sv
module rx_sfd_nibble
  import rx_sfd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              search_mode,
  input  logic              rx_valid,
  input  logic              rx_err,
  input  logic [NIB_W-1:0]  rx_nib,
  output logic              frm_start,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data,
  output logic              frm_end,
  output logic              frm_discard,
  output logic              frm_dribble
);
  rx_st_t           st;
  logic [SH_W-1:0]  sh;
  logic             err_seen;
  logic [NIB_W-1:0] prev_nib;
  logic             hit;
  logic [POS_W-1:0] hit_pos;
  logic             half;
  logic [NIB_W-1:0] data_nib;

  // named internal events, used by the logic and by the bound checker
  logic flag_evt, close_evt, data_evt;
  assign flag_evt  = (st == ST_HUNT) && rx_valid && hit;
  assign data_evt  = (st == ST_DATA) && rx_valid;
  assign close_evt = (st == ST_DATA) && !rx_valid;
  assign data_nib  = realign(rx_nib, prev_nib, sh);

  rx_sfd_hist u_hist (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid       (rx_valid),
    .search_mode (search_mode),
    .nib         (rx_nib),
    .prev_nib    (prev_nib),
    .hit         (hit),
    .hit_pos     (hit_pos)
  );

  rx_sfd_pack u_pack (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (flag_evt),
    .nib_en     (data_evt),
    .nib        (data_nib),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .half       (half)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_HUNT;
      sh          <= SH_W'(NIB_W);
      err_seen    <= 1'b0;
      frm_start   <= 1'b0;
      frm_end     <= 1'b0;
      frm_discard <= 1'b0;
      frm_dribble <= 1'b0;
    end else begin
      frm_start   <= flag_evt;
      frm_end     <= close_evt;
      frm_discard <= close_evt && err_seen;
      frm_dribble <= close_evt && half;
      if (!rx_valid)   err_seen <= 1'b0;
      else if (rx_err) err_seen <= 1'b1;
      if (flag_evt) begin
        st <= ST_DATA;
        sh <= SH_W'(hit_pos) + SH_W'(1);
      end else if (!rx_valid) begin
        st <= ST_HUNT;
      end
    end
  end
endmodule

// File: rtl/rx_sfd_nibble_chk.sv
module rx_sfd_nibble_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       search_mode,
  input logic       rx_valid,
  input logic [3:0] rx_nib,
  input logic       frm_start,
  input logic       byte_valid,
  input logic       frm_end,
  input logic       frm_discard,
  input logic       frm_dribble,
  input logic       flag_evt,
  input logic       close_evt
);
  p_start_on_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start |-> $past(rx_valid));
  p_aligned_flag_tail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_start && !$past(search_mode)) |-> ($past(rx_nib) == 4'hD));
  p_start_follows_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flag_evt |=> frm_start);
  p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);
  p_no_byte_at_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start |-> !byte_valid);
  p_end_on_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frm_end |-> !$past(rx_valid));
  p_end_follows_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
    close_evt |=> frm_end);
  p_discard_needs_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frm_discard |-> frm_end);
  p_dribble_needs_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frm_dribble |-> frm_end);
  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start |=> !frm_start);
endmodule

bind rx_sfd_nibble rx_sfd_nibble_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .search_mode (search_mode),
  .rx_valid    (rx_valid),
  .rx_nib      (rx_nib),
  .frm_start   (frm_start),
  .byte_valid  (byte_valid),
  .frm_end     (frm_end),
  .frm_discard (frm_discard),
  .frm_dribble (frm_dribble),
  .flag_evt    (flag_evt),
  .close_evt   (close_evt)
);

// File: tb/rx_sfd_nibble_bench.sv
module rx_sfd_nibble_bench;
  logic clk = 1'b0, rst_n = 1'b0, search_mode = 1'b0;
  logic rx_valid = 1'b0, rx_err = 1'b0;
  logic [3:0] rx_nib = 4'h0;
  logic frm_start, byte_valid, frm_end, frm_discard, frm_dribble;
  logic [7:0] byte_data;

  always #2 clk = ~clk;

  rx_sfd_nibble u_rx_sfd_nibble (
    .clk(clk), .rst_n(rst_n), .search_mode(search_mode), .rx_valid(rx_valid),
    .rx_err(rx_err), .rx_nib(rx_nib), .frm_start(frm_start), .byte_valid(byte_valid),
    .byte_data(byte_data), .frm_end(frm_end), .frm_discard(frm_discard),
    .frm_dribble(frm_dribble)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic sbits [0:1023];
  int nbits;
  logic [7:0] pay [0:63];

  // fields: mode, lead bits, preamble bit pairs, bytes, odd tail, error nibble (7F none), seed
  localparam logic [31:0] TBL [8] = '{
    {1'b0, 5'd0, 4'd0, 6'd3, 1'b0, 7'h7F, 8'h11},
    {1'b0, 5'd8, 4'd4, 6'd4, 1'b1, 7'h7F, 8'h2C},
    {1'b0, 5'd4, 4'd2, 6'd2, 1'b0, 7'd3,  8'h47},
    {1'b1, 5'd1, 4'd3, 6'd3, 1'b0, 7'h7F, 8'h90},
    {1'b1, 5'd2, 4'd4, 6'd2, 1'b1, 7'h7F, 8'hA5},
    {1'b1, 5'd3, 4'd1, 6'd4, 1'b0, 7'd6,  8'h3B},
    {1'b1, 5'd0, 4'd4, 6'd1, 1'b0, 7'h7F, 8'hE2},
    {1'b0, 5'd0, 4'd8, 6'd0, 1'b0, 7'h7F, 8'h00}
  };

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(logic b);
    sbits[nbits] = b;
    nbits++;
  endtask

  // serial stream: junk, preamble pairs, flag 1,0,1,0,1,0,1,1, payload LSB first, optional nibble 9h
  task automatic build(bit md, int lead, int pre, int nby, bit odd);
    logic [7:0] flag_serial = 8'b1101_0101;
    nbits = 0;
    for (int i = 0; i < lead; i++) push(md ? 1'b0 : ((i % 4) < 2));
    for (int i = 0; i < pre; i++) begin push(1'b1); push(1'b0); end
    for (int i = 0; i < 8; i++) push(flag_serial[i]);
    for (int j = 0; j < nby; j++)
      for (int b = 0; b < 8; b++) push(pay[j][b]);
    if (odd) begin push(1'b1); push(1'b0); push(1'b0); push(1'b1); end
  endtask

  task automatic run_frame(bit md, bit found, int nby, bit odd, int errn, string tag);
    int nn = (nbits + 3) / 4;
    int starts = 0, ends = 0, nbyte = 0;
    bit disc = 1'b0, drib = 1'b0;
    search_mode = md;
    for (int c = 0; c < nn + 3; c++) begin
      @(negedge clk);
      if (frm_start) starts++;
      if (byte_valid) begin
        check(nbyte < nby && byte_data == pay[nbyte], "R2", "byte value",
              int'(byte_data), (nbyte < nby) ? int'(pay[nbyte]) : -1);
        nbyte++;
      end
      if (frm_end) begin ends++; disc = frm_discard; drib = frm_dribble; end
      if (c < nn) begin
        rx_valid = 1'b1;
        for (int k = 0; k < 4; k++) rx_nib[k] = (4*c + k < nbits) ? sbits[4*c + k] : 1'b0;
        rx_err = (c == errn);
      end else begin
        rx_valid = 1'b0; rx_err = 1'b0; rx_nib = 4'h0;
      end
    end
    check(starts == int'(found), tag, "start count", starts, int'(found));
    check(ends == int'(found), found ? "R6" : "R7", "end count", ends, int'(found));
    check(nbyte == (found ? nby : 0), "R5", "byte count", nbyte, found ? nby : 0);
    check(disc == (found && errn >= 0 && errn < nn), "R8", "discard", int'(disc),
          int'(found && errn >= 0 && errn < nn));
    check(drib == (found && odd), "R9", "dribble", int'(drib), int'(found && odd));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    #1;
    check({frm_start, byte_valid, frm_end, frm_discard, frm_dribble, byte_data} == '0,
          "R1", "outputs in reset", 0, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({frm_start, byte_valid, frm_end, frm_discard, frm_dribble} == '0,
          "R1", "outputs after reset", 0, 0);

    // table walk over both modes and all bit offsets
    for (int e = 0; e < 8; e++) begin
      logic [31:0] t = TBL[e];
      for (int j = 0; j < 64; j++) pay[j] = t[7:0] + 8'(j * 37);
      build(t[31], int'(t[30:26]), int'(t[25:22]), int'(t[21:16]), t[15]);
      run_frame(t[31], 1'b1, int'(t[21:16]), t[15], (t[14:8] == 7'h7F) ? -1 : int'(t[14:8]),
                (e == 0) ? "R11" : (t[31] ? "R4" : "R3"));
    end

    // R7: valid drops before the flag completes, with an error during the hunt
    build(1'b0, 4, 4, 0, 1'b0);
    nbits = nbits - 4;
    run_frame(1'b0, 1'b0, 0, 1'b0, 2, "R7");

    // R3: flag off a nibble boundary is not seen in aligned mode
    pay[0] = 8'h00; pay[1] = 8'h00;
    build(1'b1, 2, 4, 2, 1'b0);
    run_frame(1'b0, 1'b0, 2, 1'b0, -1, "R3");

    // R10: flag bytes inside payload stay data
    pay[0] = 8'hD5; pay[1] = 8'hD5; pay[2] = 8'h5D;
    build(1'b0, 0, 2, 3, 1'b0);
    run_frame(1'b0, 1'b1, 3, 1'b0, -1, "R10");
    build(1'b1, 1, 2, 3, 1'b0);
    run_frame(1'b1, 1'b1, 3, 1'b0, -1, "R10");

    // R1: reset in mid-frame clears a pending start
    search_mode = 1'b0;
    @(negedge clk); rx_valid = 1'b1; rx_nib = 4'h5;
    @(negedge clk); rx_nib = 4'hD;
    @(negedge clk);
    check(frm_start == 1'b1, "R3", "start before reset", int'(frm_start), 1);
    rst_n = 1'b0;
    #1;
    check(frm_start == 1'b0 && frm_end == 1'b0, "R1", "async reset mid-frame",
          int'(frm_start), 0);
    rx_valid = 1'b0; rx_nib = 4'h0;
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({frm_start, byte_valid, frm_end} == '0, "R1", "quiet after reset", 0, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule